// File: doc/BRIEF.md
# Two-Pin Mode and Configuration Controller

This controller derives every operating mode of a front-end channel array from two shared control pins, an acquisition enable and a configuration write enable. The levels of the two pins select one of three steady modes: acquisition, readout or configuration. Short high pulses on the same pins produce two kinds of reset: a global reset that empties the configuration chain, and an acquisition reset that leaves configuration alone. There are no separate reset or mode pins. The one shared clock counts during acquisition, paces readout, and writes configuration bits in. The serial data pin plays two roles. During configuration it feeds the shift chain. During acquisition it is passed straight through as the clock of the test-pulse generator.

A host selects the mode by holding the pins at fixed levels and issues a reset by raising a pin for a short, bounded number of clock cycles. The length of the configuration chain (`CFG_W`) is a parameter, and so is the longest high time still accepted as a pulse (`PULSE_MAX`). The chain emits its bits on a serial output that is updated on the falling clock edge, half a period after the rising edge that moved the chain. This allows several chips to be chained and written together.

The control state machine has four states. ST_READOUT is entered when both pins are low. ST_ACQ is entered when the acquisition enable is high and the write enable is low. ST_CFG_ARM is entered from either of those states when the write enable rises. ST_CFG is entered from ST_CFG_ARM once the write enable has stayed high for more than `PULSE_MAX` edges. When the write enable drops, any state returns to ST_READOUT or ST_ACQ. Each pin also has its own pulse qualifier with the states QS_IDLE, QS_HIGH (counting) and QS_OVER (too long or not gated). A qualifier fires when it leaves QS_HIGH on a low level.

Top module: `pin_mode_ctrl`

## Requirements
- R1: On a rising edge where `acq_en`=1 and `cfg_wen`=0, `mode` becomes 2'b01 (acquisition) after that edge.
- R2: On a rising edge where both pins are low, `mode` becomes 2'b00 (readout) after that edge.
- R3: On a rising edge where `cfg_wen`=1, `mode` becomes 2'b10 (configuration) after that edge, whatever `acq_en` is.
- R4: If `cfg_wen` is high for between 1 and `PULSE_MAX` rising edges and is then sampled low, `acq_rst` is high for exactly one cycle after that low edge. A longer high time gives no pulse.
- R5: If `acq_en` is high for between 1 and `PULSE_MAX` rising edges, with `cfg_wen` high on every one of them, and is then sampled low, `glob_rst` is high for exactly one cycle after that edge. The following edge sets `cfg_q` to all zeros.
- R6: An `acq_en` high time longer than `PULSE_MAX` edges gives no `glob_rst`. An `acq_en` high time seen while `cfg_wen` is low also gives none.
- R7: While in ST_CFG, every rising edge with `cfg_wen`=1 shifts `cfg_q` left by one and enters `ser_in` at bit 0, so the first bit written ends at the MSB. Shifting starts at the edge numbered `PULSE_MAX`+2 of a write-enable high period. The edges before it shift nothing.
- R8: `ser_out` takes the MSB of `cfg_q` at each falling clock edge. It therefore changes half a period after the rising edge that shifted the chain.
- R9: `pulser_clk` equals `ser_in` combinationally while `mode` is acquisition, and is 0 in every other mode.
- R10: An acquisition reset (a qualified `cfg_wen` pulse) leaves `cfg_q` unchanged.
- R11: While `rst_n` is low, `mode` is readout and `acq_rst`, `glob_rst`, `cfg_q`, `ser_out` and `pulser_clk` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock: counter, readout or write-in clock depending on mode |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| acq_en | input | 1 | Acquisition enable pin |
| cfg_wen | input | 1 | Configuration write enable pin |
| ser_in | input | 1 | Serial configuration data; pulser clock source during acquisition |
| mode | output | 2 | 00 readout, 01 acquisition, 10 configuration |
| acq_rst | output | 1 | One-cycle acquisition reset pulse |
| glob_rst | output | 1 | One-cycle global reset pulse |
| cfg_q | output | CFG_W | Configuration chain contents |
| ser_out | output | 1 | Serial chain output, updated on the falling edge |
| pulser_clk | output | 1 | Test-pulser clock, gated by acquisition mode |

## Verification
The properties assume that both pins change only between clock edges and hold steady across each rising edge. The bench meets this by driving every input one nanosecond after a falling edge. The properties also assume that the write enable is not raised again in the cycle right after an acquisition reset pulse. Every pulse sequence in the bench is followed by at least one settled cycle, so this holds. Pulse lengths are swept from 1 to one past the limit, and all 256 chain values are written, so each qualifier reaches both its firing path and its QS_OVER path.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    typedef enum logic [1:0] {
        MODE_READOUT = 2'b00,
        MODE_ACQ     = 2'b01,
        MODE_CFG     = 2'b10
    } mode_e;

    typedef enum logic [1:0] {
        ST_READOUT,
        ST_ACQ,
        ST_CFG_ARM,
        ST_CFG
    } ctl_state_e;

    typedef enum logic [1:0] {
        QS_IDLE,
        QS_HIGH,
        QS_OVER
    } qual_state_e;

endpackage

// File: rtl/mcc_pulse_qual.sv
module mcc_pulse_qual
    import mcc_pkg::*;
#(
    parameter int MAX_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic gate,
    output logic fire
);
    localparam int CW = $clog2(MAX_LEN + 1);

    qual_state_e     state, nxt_state;
    logic [CW-1:0]   cnt, nxt_cnt;

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        unique case (state)
            QS_IDLE: begin
                if (lvl && gate) begin
                    nxt_state = QS_HIGH;
                    nxt_cnt   = CW'(1);
                end else if (lvl) begin
                    nxt_state = QS_OVER;
                end
            end
            QS_HIGH: begin
                if (!lvl) begin
                    nxt_state = QS_IDLE;
                end else if (!gate || cnt == CW'(MAX_LEN)) begin
                    nxt_state = QS_OVER;
                end else begin
                    nxt_cnt = cnt + CW'(1);
                end
            end
            QS_OVER: begin
                if (!lvl) nxt_state = QS_IDLE;
            end
            default: nxt_state = QS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= QS_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fire <= 1'b0;
        else        fire <= (state == QS_HIGH) && !lvl;
    end

endmodule

// File: rtl/mcc_mode_fsm.sv
module mcc_mode_fsm
    import mcc_pkg::*;
#(
    parameter int ARM_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acq_en,
    input  logic       cfg_wen,
    output logic [1:0] mode,
    output logic       shift_en
);
    localparam int CW = $clog2(ARM_LEN + 1);

    ctl_state_e    state, nxt_state;
    logic [CW-1:0] arm_cnt, nxt_arm_cnt;

    always_comb begin
        nxt_state   = state;
        nxt_arm_cnt = arm_cnt;
        if (!cfg_wen) begin
            nxt_state   = acq_en ? ST_ACQ : ST_READOUT;
            nxt_arm_cnt = '0;
        end else begin
            unique case (state)
                ST_READOUT, ST_ACQ: begin
                    nxt_state   = ST_CFG_ARM;
                    nxt_arm_cnt = CW'(1);
                end
                ST_CFG_ARM: begin
                    if (arm_cnt == CW'(ARM_LEN)) nxt_state = ST_CFG;
                    else                         nxt_arm_cnt = arm_cnt + CW'(1);
                end
                ST_CFG:  nxt_state = ST_CFG;
                default: nxt_state = ST_READOUT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_READOUT;
            arm_cnt <= '0;
        end else begin
            state   <= nxt_state;
            arm_cnt <= nxt_arm_cnt;
        end
    end

    always_comb begin
        mode     = MODE_READOUT;
        shift_en = 1'b0;
        unique case (state)
            ST_READOUT: mode = MODE_READOUT;
            ST_ACQ:     mode = MODE_ACQ;
            ST_CFG_ARM: mode = MODE_CFG;
            ST_CFG: begin
                mode     = MODE_CFG;
                shift_en = cfg_wen;
            end
            default:    mode = MODE_READOUT;
        endcase
    end

endmodule

// File: rtl/mcc_cfg_chain.sv
module mcc_cfg_chain #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift,
    input  logic             din,
    output logic [WIDTH-1:0] cfg_q,
    output logic             ser_out
);
    localparam int MSB = WIDTH - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cfg_q <= '0;
        else if (clr)   cfg_q <= '0;
        else if (shift) cfg_q <= {cfg_q[MSB-1:0], din};
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) ser_out <= 1'b0;
        else        ser_out <= cfg_q[MSB];
    end

endmodule

// File: rtl/pin_mode_ctrl.sv
module pin_mode_ctrl
    import mcc_pkg::*;
#(
    parameter int CFG_W     = 32,
    parameter int PULSE_MAX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_en,
    input  logic             cfg_wen,
    input  logic             ser_in,
    output logic [1:0]       mode,
    output logic             acq_rst,
    output logic             glob_rst,
    output logic [CFG_W-1:0] cfg_q,
    output logic             ser_out,
    output logic             pulser_clk
);
    logic shift_en;

    mcc_mode_fsm #(.ARM_LEN(PULSE_MAX)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .acq_en   (acq_en),
        .cfg_wen  (cfg_wen),
        .mode     (mode),
        .shift_en (shift_en)
    );

    mcc_pulse_qual #(.MAX_LEN(PULSE_MAX)) u_wen_q (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (cfg_wen),
        .gate  (1'b1),
        .fire  (acq_rst)
    );

    mcc_pulse_qual #(.MAX_LEN(PULSE_MAX)) u_ena_q (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (acq_en),
        .gate  (cfg_wen),
        .fire  (glob_rst)
    );

    mcc_cfg_chain #(.WIDTH(CFG_W)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (glob_rst),
        .shift   (shift_en),
        .din     (ser_in),
        .cfg_q   (cfg_q),
        .ser_out (ser_out)
    );

    assign pulser_clk = (mode == MODE_ACQ) && ser_in;

endmodule

// File: rtl/pin_mode_ctrl_chk.sv
module pin_mode_ctrl_chk #(
    parameter int CFG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acq_en,
    input logic             cfg_wen,
    input logic             ser_in,
    input logic [1:0]       mode,
    input logic             acq_rst,
    input logic             glob_rst,
    input logic [CFG_W-1:0] cfg_q,
    input logic             pulser_clk
);
    logic live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // R1
    a_r1_acq_mode: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(acq_en) && !$past(cfg_wen) |-> mode == 2'b01);
    // R2
    a_r2_ro_mode: assert property (@(posedge clk) disable iff (!rst_n)
        live && !$past(acq_en) && !$past(cfg_wen) |-> mode == 2'b00);
    // R3
    a_r3_cfg_mode: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(cfg_wen) |-> mode == 2'b10);
    // R4
    a_r4_acq_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        acq_rst |=> !acq_rst);
    // R5
    a_r5_glob_single: assert property (@(posedge clk) disable iff (!rst_n)
        glob_rst |=> !glob_rst);
    a_r5_glob_clears: assert property (@(posedge clk) disable iff (!rst_n)
        glob_rst |=> cfg_q == '0);
    // R6
    a_r6_glob_gated: assert property (@(posedge clk) disable iff (!rst_n)
        glob_rst |-> $past(cfg_wen, 2));
    // R9
    a_r9_pulser_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b01 |-> !pulser_clk);
    // R10
    a_r10_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
        acq_rst && !glob_rst |=> $stable(cfg_q));

endmodule

bind pin_mode_ctrl pin_mode_ctrl_chk #(.CFG_W(CFG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acq_en     (acq_en),
    .cfg_wen    (cfg_wen),
    .ser_in     (ser_in),
    .mode       (mode),
    .acq_rst    (acq_rst),
    .glob_rst   (glob_rst),
    .cfg_q      (cfg_q),
    .pulser_clk (pulser_clk)
);

// File: tb/sim_pin_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pin_mode_ctrl;
    localparam int W = 8;
    localparam int N = 3;
    localparam logic [W-1:0] MASK = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acq_en = 1'b0, cfg_wen = 1'b0, ser_in = 1'b0;
    logic [1:0] mode;
    logic acq_rst, glob_rst, ser_out, pulser_clk;
    logic [W-1:0] cfg_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pin_mode_ctrl #(.CFG_W(W), .PULSE_MAX(N)) u0 (
        .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .cfg_wen(cfg_wen),
        .ser_in(ser_in), .mode(mode), .acq_rst(acq_rst), .glob_rst(glob_rst),
        .cfg_q(cfg_q), .ser_out(ser_out), .pulser_clk(pulser_clk)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic [W-1:0] v);
        cfg_wen = 1'b1;
        acq_en  = 1'b0;
        ser_in  = 1'b0;
        repeat (N + 1) step();
        for (int b = W - 1; b >= 0; b--) begin
            ser_in = v[b];
            step();
        end
        ser_in = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        #1;
        chk("R11 mode", mode, 0);
        chk("R11 acq_rst", acq_rst, 0);
        chk("R11 glob_rst", glob_rst, 0);
        chk("R11 cfg_q", cfg_q, 0);
        chk("R11 ser_out", ser_out, 0);
        chk("R11 pulser_clk", pulser_clk, 0);
        step(); step();
        rst_n = 1'b1;
        step();

        // R1 acquisition mode and R9 pulser pass-through
        acq_en = 1'b1;
        step();
        chk("R1 mode acq", mode, 1);
        for (int i = 0; i < 4; i++) begin
            ser_in = i[0];
            #0.5;
            chk("R9 pulser follows ser_in", pulser_clk, i[0]);
            step();
        end
        // R2 readout, pulser silent
        acq_en = 1'b0;
        ser_in = 1'b1;
        step();
        chk("R2 mode readout", mode, 0);
        chk("R9 pulser quiet in readout", pulser_clk, 0);
        // R6 ena pulse with wen low: no global reset
        acq_en = 1'b1; step(); acq_en = 1'b0; ser_in = 1'b0; step();
        chk("R6 ungated ena pulse", glob_rst, 0);
        step();

        // R3 R7 R8 full sweep of chain values
        for (int v = 0; v < 256; v++) begin
            cfg_write(W'(v));
            chk("R3 mode cfg", mode, 2);
            chk("R7 chain value", cfg_q, v);
            chk("R8 ser_out before edge", ser_out, v >> 7);
            @(posedge clk); #1;
            chk("R8 ser_out held past rising edge", ser_out, v >> 7);
            chk("R7 shift by one", cfg_q, (v << 1) & MASK);
            chk("R9 pulser quiet in cfg", pulser_clk, 0);
            @(negedge clk); #1;
            chk("R8 ser_out after falling edge", ser_out, (v >> 6) & 1);
        end

        // R5 R6 global reset pulse length sweep (wen held high)
        for (int k = 1; k <= N + 1; k++) begin
            cfg_write(8'hC3);
            acq_en = 1'b1;
            repeat (k) step();
            acq_en = 1'b0;
            step();
            chk("R5 glob_rst pulse", glob_rst, (k <= N) ? 1 : 0);
            step();
            chk("R5 glob_rst single", glob_rst, 0);
            chk("R5 R6 cfg after ena pulse", cfg_q,
                (k <= N) ? 0 : ((64'hC3 << (k + 2)) & MASK));
            chk("R4 no acq_rst during cfg", acq_rst, 0);
        end

        // R4 R10 acquisition reset sweep, from readout and acquisition
        for (int e = 0; e < 2; e++) begin
            for (int k = 1; k <= N + 1; k++) begin
                cfg_write(8'h5A);
                cfg_wen = 1'b0;
                acq_en  = e[0];
                step(); step();
                cfg_wen = 1'b1;
                repeat (k) step();
                chk("R3 mode cfg during wen pulse", mode, 2);
                cfg_wen = 1'b0;
                step();
                chk("R4 acq_rst pulse", acq_rst, (k <= N) ? 1 : 0);
                chk("R6 no glob_rst on wen pulse", glob_rst, 0);
                chk("R1 R2 mode after wen pulse", mode, e);
                step();
                chk("R4 acq_rst single", acq_rst, 0);
                chk("R10 cfg kept", cfg_q, 8'h5A);
            end
        end

        // R6 long ena with wen high: no reset
        cfg_write(8'h81);
        acq_en = 1'b1;
        repeat (N + 4) step();
        chk("R6 long ena no reset", glob_rst, 0);
        acq_en = 1'b0;
        step();
        chk("R6 long ena no reset at fall", glob_rst, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule